// File: doc/BRIEF.md
# Prefix-Extended Move Instruction Decoder

This block decodes the fixed 16-bit instruction words of a transport-triggered core, where every instruction moves a value from a source to a destination register. Each accepted word is split into a format bit, a source field and a destination field. Each field becomes a module number and a register index. An immediate-format word instead yields a 16-bit immediate value. The decoded fields appear, registered, one cycle after the word is presented.

Some operands do not fit in the word. Examples are an immediate with a nonzero high byte, a long absolute branch target, or a register above the directly reachable range of its module. For these the core first writes a one-shot prefix byte. An immediate-format move to the prefix location (destination module 11, subindex 0) is absorbed by the decoder and produces no decoded output. The next ordinary instruction then takes its immediate high byte and its index extension bits from that byte, and the prefix is dropped afterwards.

The prefix handling is a two-state machine. PLAIN means no prefix is held, and ARMED means a prefix is held. These transitions are defined:
- PLAIN to ARMED on an accepted prefix write.
- ARMED to ARMED on a further prefix write, which replaces the held byte.
- ARMED to PLAIN on an accepted ordinary instruction.
- Both states hold while no word is offered.

Top module: `move_decoder`

## Requirements
- R1: A word with bit 15 = 0 is immediate format. After decode, `src_is_imm` = 1, `imm_value[7:0]` = word[7:0], `src_module` = 0 and `src_index` = 0. The high byte of `imm_value` is 0 when no prefix is held.
- R2: A word with bit 15 = 1 is register format. After decode, `src_is_imm` = 0, `imm_value` = 0, `src_module` = word[3:0] and `src_index[3:0]` = word[7:4].
- R3: For every ordinary word, `dst_module` = word[11:8] and `dst_index[2:0]` = word[14:12].
- R4: An accepted immediate-format word with word[14:8] = 7'h0B is a prefix write. It produces no `dec_valid` pulse, and `prefix_pending` reads 1 in the following cycle.
- R5: For an immediate-format word that follows a prefix write, `imm_value[15:8]` equals the prefix byte.
- R6: A held prefix affects the source index as follows. If the source module is peripheral (bit 3 = 0), `src_index[4]` = prefix bit 0. If the source module is a system module (bit 3 = 1), `src_index[4]` = 0.
- R7: A held prefix affects the destination index as follows. If the destination module is peripheral, `dst_index[4:3]` = prefix bits 5:4. If it is a system module, `dst_index[3]` = prefix bit 4 and `dst_index[4]` = 0.
- R8: After exactly one ordinary instruction, the prefix is consumed. `prefix_pending` returns to 0, and the next instruction decodes with zero high byte and zero extension bits.
- R9: A prefix write while a prefix is already held replaces the held byte.
- R10: While `in_valid` = 0, `dec_valid` stays 0 and a held prefix is kept unchanged.
- R11: `dec_valid` is high for exactly the one cycle after each accepted ordinary instruction.
- R12: After reset, `dec_valid` = 0, `prefix_pending` = 0, and all decoded fields are 0.
- R13: A register-format word (bit 15 = 1) aimed at the prefix location is an ordinary move. It is decoded with a `dec_valid` pulse and it consumes any held prefix.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word offered this cycle |
| in_word | input | 16 | Instruction word |
| dec_valid | output | 1 | Decoded fields valid (one-cycle pulse) |
| src_is_imm | output | 1 | Source is an immediate |
| imm_value | output | 16 | Immediate value, prefix byte in the high half |
| src_module | output | 4 | Source module number |
| src_index | output | 5 | Source register index |
| dst_module | output | 4 | Destination module number |
| dst_index | output | 5 | Destination register index |
| prefix_pending | output | 1 | A prefix byte is held for the next instruction |

## Verification
A wrong prefix state can fail in two ways. A prefix that is lost is visible at the ports on the very next decoded instruction, as a high byte or extension bits that read zero when they should not. A prefix that lingers appears one instruction later, as nonzero extension bits on a word that had no prefix. A sweep over every 16-bit word, run in order with a reference model of the prefix state, exposes both faults within one or two cycles of the instruction concerned. Sweeps over every prefix byte, aimed at peripheral and system modules, show any wrong extension bit or masking rule in the cycle after the affected word.

// File: rtl/move_decoder_pkg.sv
package move_decoder_pkg;

    typedef enum logic [0:0] {
        ST_PLAIN = 1'b0,
        ST_ARMED = 1'b1
    } pfx_state_e;

    // modules with the top bit of their number set are system modules
    function automatic logic is_system_module(input logic [3:0] mod);
        return mod[3];
    endfunction

endpackage

// File: rtl/move_decoder_prefix_fsm.sv
module move_decoder_prefix_fsm
    import move_decoder_pkg::*;
#(
    parameter int WORD_W   = 16,
    parameter int MOD_W    = 4,
    parameter int SUB_W    = 3,
    parameter int PFX_MOD  = 11,
    parameter int PFX_SUB  = 0,
    localparam int HALF_W  = WORD_W / 2,
    localparam int DST_W   = MOD_W + SUB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    output logic              pfx_word,
    output logic              pfx_live,
    output logic [HALF_W-1:0] pfx_byte
);

    localparam logic [DST_W-1:0] PFX_ADDR = {SUB_W'(PFX_SUB), MOD_W'(PFX_MOD)};

    pfx_state_e state, state_nx;

    // immediate-format move whose raw destination field is the prefix location
    always_comb begin
        pfx_word = !in_word[WORD_W-1] && (in_word[WORD_W-2 -: DST_W] == PFX_ADDR);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_PLAIN;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_PLAIN: if (in_valid && pfx_word)  state_nx = ST_ARMED;
            ST_ARMED: if (in_valid && !pfx_word) state_nx = ST_PLAIN;
            default:  state_nx = ST_PLAIN;
        endcase
    end

    // payload: captured on a prefix write, cleared once an ordinary word uses it
    always_ff @(posedge clk) begin
        if (!rst_n)        pfx_byte <= '0;
        else if (in_valid) pfx_byte <= pfx_word ? in_word[HALF_W-1:0] : '0;
    end

    always_comb begin
        pfx_live = (state == ST_ARMED);
    end

    p_arm_on_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && pfx_word) |=> pfx_live);

    p_consumed_after_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !pfx_word) |=> (!pfx_live && pfx_byte == '0));

    p_held_while_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(pfx_live) && $stable(pfx_byte)));

endmodule

// File: rtl/move_decoder_fields.sv
module move_decoder_fields
    import move_decoder_pkg::*;
#(
    parameter int WORD_W     = 16,
    parameter int MOD_W      = 4,
    parameter int SUB_W      = 3,
    parameter int SRC_EXT_W  = 1,
    parameter int DST_EXT_W  = 2,
    parameter int SYS_EXT_W  = 1,
    parameter int DST_EXT_LSB = 4,
    localparam int HALF_W    = WORD_W / 2,
    localparam int SRC_BASE_W = HALF_W - MOD_W,
    localparam int SRC_IDX_W = SRC_BASE_W + SRC_EXT_W,
    localparam int DST_IDX_W = SUB_W + DST_EXT_W
) (
    input  logic [WORD_W-1:0]    in_word,
    input  logic [HALF_W-1:0]    pfx_byte,
    output logic                 f_is_imm,
    output logic [WORD_W-1:0]    f_imm,
    output logic [MOD_W-1:0]     f_src_mod,
    output logic [SRC_IDX_W-1:0] f_src_idx,
    output logic [MOD_W-1:0]     f_dst_mod,
    output logic [DST_IDX_W-1:0] f_dst_idx
);

    logic [MOD_W-1:0]     raw_src_mod;
    logic [SRC_BASE_W-1:0] raw_src_idx;
    logic [SRC_EXT_W-1:0] src_ext;
    logic [DST_EXT_W-1:0] dst_ext_raw;
    logic [DST_EXT_W-1:0] dst_ext;

    always_comb begin
        f_is_imm    = !in_word[WORD_W-1];
        raw_src_mod = in_word[MOD_W-1:0];
        raw_src_idx = in_word[HALF_W-1:MOD_W];
        f_dst_mod   = in_word[HALF_W +: MOD_W];
        dst_ext_raw = pfx_byte[DST_EXT_LSB +: DST_EXT_W];
        // system modules take no source extension
        src_ext = is_system_module(raw_src_mod) ? '0 : pfx_byte[SRC_EXT_W-1:0];
    end

    // system destinations reach fewer registers: mask the upper extension bits
    generate
        if (DST_EXT_W > SYS_EXT_W) begin : g_sys_mask
            localparam logic [DST_EXT_W-1:0] SYS_MASK =
                {{(DST_EXT_W-SYS_EXT_W){1'b0}}, {SYS_EXT_W{1'b1}}};
            always_comb begin
                dst_ext = is_system_module(f_dst_mod) ? (dst_ext_raw & SYS_MASK) : dst_ext_raw;
            end
        end else begin : g_no_mask
            always_comb begin
                dst_ext = dst_ext_raw;
            end
        end
    endgenerate

    always_comb begin
        f_dst_idx = {dst_ext, in_word[HALF_W+MOD_W +: SUB_W]};
        if (f_is_imm) begin
            f_imm     = {pfx_byte, in_word[HALF_W-1:0]};
            f_src_mod = '0;
            f_src_idx = '0;
        end else begin
            f_imm     = '0;
            f_src_mod = raw_src_mod;
            f_src_idx = {src_ext, raw_src_idx};
        end
    end

endmodule

// File: rtl/move_decoder.sv
module move_decoder
    import move_decoder_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int MOD_W       = 4,
    parameter int SUB_W       = 3,
    parameter int SRC_EXT_W   = 1,
    parameter int DST_EXT_W   = 2,
    parameter int SYS_EXT_W   = 1,
    parameter int DST_EXT_LSB = 4,
    parameter int PFX_MOD     = 11,
    parameter int PFX_SUB     = 0,
    localparam int HALF_W     = WORD_W / 2,
    localparam int SRC_IDX_W  = HALF_W - MOD_W + SRC_EXT_W,
    localparam int DST_IDX_W  = SUB_W + DST_EXT_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [WORD_W-1:0]    in_word,
    output logic                 dec_valid,
    output logic                 src_is_imm,
    output logic [WORD_W-1:0]    imm_value,
    output logic [MOD_W-1:0]     src_module,
    output logic [SRC_IDX_W-1:0] src_index,
    output logic [MOD_W-1:0]     dst_module,
    output logic [DST_IDX_W-1:0] dst_index,
    output logic                 prefix_pending
);

    logic                 pfx_word;
    logic                 pfx_live;
    logic [HALF_W-1:0]    pfx_byte;
    logic                 f_is_imm;
    logic [WORD_W-1:0]    f_imm;
    logic [MOD_W-1:0]     f_src_mod;
    logic [SRC_IDX_W-1:0] f_src_idx;
    logic [MOD_W-1:0]     f_dst_mod;
    logic [DST_IDX_W-1:0] f_dst_idx;
    logic                 accept;

    move_decoder_prefix_fsm #(
        .WORD_W (WORD_W), .MOD_W (MOD_W), .SUB_W (SUB_W),
        .PFX_MOD(PFX_MOD), .PFX_SUB(PFX_SUB)
    ) u_prefix (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_valid(in_valid),
        .in_word (in_word),
        .pfx_word(pfx_word),
        .pfx_live(pfx_live),
        .pfx_byte(pfx_byte)
    );

    move_decoder_fields #(
        .WORD_W(WORD_W), .MOD_W(MOD_W), .SUB_W(SUB_W),
        .SRC_EXT_W(SRC_EXT_W), .DST_EXT_W(DST_EXT_W),
        .SYS_EXT_W(SYS_EXT_W), .DST_EXT_LSB(DST_EXT_LSB)
    ) u_fields (
        .in_word  (in_word),
        .pfx_byte (pfx_byte),
        .f_is_imm (f_is_imm),
        .f_imm    (f_imm),
        .f_src_mod(f_src_mod),
        .f_src_idx(f_src_idx),
        .f_dst_mod(f_dst_mod),
        .f_dst_idx(f_dst_idx)
    );

    always_comb begin
        accept         = in_valid && !pfx_word;
        prefix_pending = pfx_live;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid  <= 1'b0;
            src_is_imm <= 1'b0;
            imm_value  <= '0;
            src_module <= '0;
            src_index  <= '0;
            dst_module <= '0;
            dst_index  <= '0;
        end else begin
            dec_valid <= accept;
            if (accept) begin
                src_is_imm <= f_is_imm;
                imm_value  <= f_imm;
                src_module <= f_src_mod;
                src_index  <= f_src_idx;
                dst_module <= f_dst_mod;
                dst_index  <= f_dst_idx;
            end
        end
    end

    p_no_pulse_on_prefix_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && pfx_word) |=> !dec_valid);

    p_pulse_after_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !pfx_word) |=> dec_valid);

    p_quiet_when_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !dec_valid);

    p_plain_imm_high_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && src_is_imm && !$past(pfx_live)) |-> (imm_value[WORD_W-1:HALF_W] == '0));

    p_sys_src_no_ext_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !src_is_imm && src_module[MOD_W-1]) |-> (src_index[SRC_IDX_W-1] == 1'b0));

    generate
        if (DST_EXT_W > SYS_EXT_W) begin : g_sys_dst_chk
            p_sys_dst_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (dec_valid && dst_module[MOD_W-1]) |-> (dst_index[DST_IDX_W-1] == 1'b0));
        end
    endgenerate

endmodule

// File: tb/move_decoder_bench.sv
module move_decoder_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_word = '0;
    logic        dec_valid, src_is_imm, prefix_pending;
    logic [15:0] imm_value;
    logic [3:0]  src_module, dst_module;
    logic [4:0]  src_index, dst_index;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    // model of the held prefix
    bit         m_pend = 1'b0;
    logic [7:0] m_byte = '0;

    always #4 clk = ~clk;

    move_decoder u_move_decoder (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .dec_valid(dec_valid), .src_is_imm(src_is_imm), .imm_value(imm_value),
        .src_module(src_module), .src_index(src_index),
        .dst_module(dst_module), .dst_index(dst_index),
        .prefix_pending(prefix_pending)
    );

    task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [34:0] expect_fields(input logic [15:0] w, input bit pend,
                                                  input logic [7:0] b);
        logic        imm_f;
        logic [15:0] imm;
        logic [3:0]  smod;
        logic [4:0]  sidx, didx;
        logic [1:0]  de;
        logic [7:0]  hb;
        hb    = pend ? b : 8'h00;
        imm_f = (w[15] == 1'b0);
        imm   = imm_f ? {hb, w[7:0]} : 16'h0;
        smod  = imm_f ? 4'h0 : w[3:0];
        sidx  = imm_f ? 5'h0 : {(w[3] ? 1'b0 : hb[0]), w[7:4]};
        de    = hb[5:4];
        if (w[11]) de[1] = 1'b0;
        didx  = {de, w[14:12]};
        return {imm_f, imm, smod, sidx, w[11:8], didx};
    endfunction

    function automatic logic [34:0] actual_fields();
        return {src_is_imm, imm_value, src_module, src_index, dst_module, dst_index};
    endfunction

    // drive at the falling edge, look at the registered result one full cycle later
    task automatic step(input logic [15:0] w, input bit v, input string tag);
        logic [34:0] ef;
        bit          is_pfx;
        bit          exp_valid;
        is_pfx    = v && (w[15] == 1'b0) && (w[14:8] == 7'h0B);
        exp_valid = v && !is_pfx;
        ef        = expect_fields(w, m_pend, m_byte);
        in_valid  = v;
        in_word   = w;
        @(negedge clk);
        if (is_pfx) begin
            m_pend = 1'b1;
            m_byte = w[7:0];
        end else if (v) begin
            m_pend = 1'b0;
            m_byte = 8'h00;
        end
        if (exp_valid)
            check({27'd0, dec_valid, prefix_pending, actual_fields()},
                  {27'd0, 1'b1, m_pend, ef}, tag);
        else
            check({62'd0, dec_valid, prefix_pending}, {62'd0, 1'b0, m_pend}, tag);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R12: reset state
        check({29'd0, dec_valid, prefix_pending, actual_fields()}, 64'd0, "R12 reset");
        rst_n = 1'b1;
        @(negedge clk);
        check({62'd0, dec_valid, prefix_pending}, 64'd0, "R12 after release");

        // full sweep in order; the 0x0Bxx run is a chain of prefix rewrites (R9)
        for (int w = 0; w < 65536; w++) begin
            if (w[15] == 1'b0 && w[14:8] == 7'h0B) step(16'(w), 1'b1, "R4 R9 prefix chain");
            else if (w[15] == 1'b0)                step(16'(w), 1'b1, "R1 R3 R11 immediate");
            else                                   step(16'(w), 1'b1, "R2 R3 R11 register");
        end

        // every prefix byte against peripheral, system and immediate targets
        for (int b = 0; b < 256; b++) begin
            step({8'h0B, 8'(b)}, 1'b1, "R4 prefix write");
            step(16'h1234, 1'b0, "R10 idle keeps prefix");
            step(16'hD2A3, 1'b1, "R6 R7 peripheral extension");
            step(16'h0000, 1'b0, "R11 single pulse");
            step({8'h0B, 8'(b)}, 1'b1, "R4 prefix write");
            step(16'hFC69, 1'b1, "R6 R7 system masking");
            step({8'h0B, 8'(b)}, 1'b1, "R4 prefix write");
            step(16'h0312, 1'b1, "R5 immediate high byte");
            step(16'h0312, 1'b1, "R8 prefix consumed");
        end

        // R9: replacement of a held prefix
        step(16'h0B11, 1'b1, "R9 first prefix");
        step(16'h0B22, 1'b1, "R9 second prefix");
        step(16'h0540, 1'b1, "R9 latest byte used");
        check({48'd0, imm_value}, 64'h2240, "R9 high byte");

        // R13: register-format word at the prefix location is ordinary
        step(16'h0BF0, 1'b1, "R4 prefix write");
        step(16'h8B55, 1'b1, "R13 register move to prefix location");
        check({63'd0, prefix_pending}, 64'd0, "R13 prefix consumed");
        step(16'h0077, 1'b1, "R13 R8 plain after");

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule